// File: doc/BRIEF.md
# Hypervisor-level interrupt arbiter

This block picks the interrupt that the hypervisor privilege level should take next. It looks at a pending vector and an enable vector, indexed by interrupt cause number. A source competes only when both its pending bit and its enable bit are set. A fixed ranking then chooses one winner from seven sources: three supervisor sources, the hypervisor guest-external source, and three virtual-supervisor sources. The block reports a take flag and the cause number of the winner.

The ranking does not follow cause numbers. Supervisor sources come first, then guest external, then the virtual-supervisor group. Inside that last group, software ranks above timer. Gating by the global interrupt enable, privilege checks, delegation and trap vectoring belong to the surrounding trap logic. The two vectors and the result are level signals that the trap logic samples, not a stream, so all pins are plain with no handshake. A parameter chooses between a purely combinational result and a result registered by one clock.

Top module: `hs_irq_select`

## Requirements
- R1: A source is a candidate only when its bit is set in both `pend_i` and `en_i`. A pending bit without its enable bit, or an enable bit without its pending bit, never produces a take.
- R2: Supervisor external (bit 9) wins over every other candidate.
- R3: Supervisor software (bit 1) wins over supervisor timer (bit 5) and over all lower-ranked sources.
- R4: Supervisor timer (bit 5) wins over guest external (bit 12) and the virtual-supervisor group.
- R5: Guest external (bit 12) wins over virtual-supervisor external (bit 10).
- R6: Virtual-supervisor external (bit 10) wins over virtual-supervisor software (bit 2) and virtual-supervisor timer (bit 6).
- R7: Virtual-supervisor software (bit 2) wins over virtual-supervisor timer (bit 6).
- R8: When `take_o` is 1, `cause_o` equals the bit index of the winning source. The value is unsigned binary.
- R9: When no candidate exists, `take_o` is 0 and `cause_o` is 0.
- R10: Bits 0, 3, 4, 7, 8 and 11 of the vectors are not sources. Setting them in both vectors gives no take.
- R11: With `OUT_REG`=1 (the default), the outputs show the inputs sampled at the previous rising clock edge. While `rst_n` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | VEC_W | Pending vector, indexed by cause number |
| en_i | input | VEC_W | Enable vector, indexed by cause number |
| take_o | output | 1 | An enabled pending source exists |
| cause_o | output | $clog2(VEC_W) | Cause number of the winner, 0 when none |

## Verification
The bench targets each pair of sources that sit next to each other in the ranking. A design that ranked by cause number would let bit 12 beat bit 9 and bit 6 beat bit 2. The bench also sets pending bits with their enables cleared, and the reverse. A design that ORed the two vectors, or looked at only one of them, would report a take there. Non-source bits are set in both vectors to catch a generic priority encoder that treats every bit as a source. The idle case is checked for a cause of 0, which catches a design that leaves a stale winner number on the output. Dense random vectors then check the full ranking against a model built from the requirements.

// File: rtl/hs_irq_pkg.sv
package hs_irq_pkg;
  localparam int NUM_SRC = 7;
  localparam int MIN_VEC_W = 13;

  // Source cause number by rank, 0 = highest priority.
  function automatic int rank_bit(input int r);
    case (r)
      0: return 9;
      1: return 1;
      2: return 5;
      3: return 12;
      4: return 10;
      5: return 2;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/hs_irq_cand.sv
module hs_irq_cand
  import hs_irq_pkg::*;
#(
  parameter int VEC_W = 13
) (
  input  logic [VEC_W-1:0]   pend_i,
  input  logic [VEC_W-1:0]   en_i,
  output logic [NUM_SRC-1:0] cand_o
);
  // Rank-ordered candidates; bits that are not sources are never looked at.
  for (genvar r = 0; r < NUM_SRC; r++) begin : g_rank
    localparam int B = rank_bit(r);
    assign cand_o[r] = pend_i[B] & en_i[B];
  end
endmodule

// File: rtl/hs_irq_pick.sv
module hs_irq_pick
  import hs_irq_pkg::*;
#(
  parameter int CAUSE_W = 4
) (
  input  logic [NUM_SRC-1:0] cand_i,
  output logic               found_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [NUM_SRC-1:0] grant;

  assign grant[0] = cand_i[0];
  for (genvar r = 1; r < NUM_SRC; r++) begin : g_grant
    assign grant[r] = cand_i[r] & ~(|cand_i[r-1:0]);
  end

  assign found_o = |cand_i;

  always_comb begin
    cause_o = '0;
    for (int r = 0; r < NUM_SRC; r++) begin
      if (grant[r]) cause_o = cause_o | CAUSE_W'(rank_bit(r));
    end
  end

  // R8
  always_comb begin
    grant_onehot_chk: assert ($onehot0(grant));
  end
endmodule

// File: rtl/hs_irq_out.sv
module hs_irq_out #(
  parameter int CAUSE_W = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               found_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        take_o  <= 1'b0;
        cause_o <= '0;
      end else begin
        take_o  <= found_i;
        cause_o <= cause_i;
      end
    end
  end else begin : g_comb
    assign take_o  = found_i;
    assign cause_o = cause_i;
  end
endmodule

// File: rtl/hs_irq_select.sv
module hs_irq_select
  import hs_irq_pkg::*;
#(
  parameter int VEC_W   = 13,
  parameter bit OUT_REG = 1'b1,
  localparam int CAUSE_W = $clog2(VEC_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VEC_W-1:0]   pend_i,
  input  logic [VEC_W-1:0]   en_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [NUM_SRC-1:0] cand;
  logic               found;
  logic [CAUSE_W-1:0] cause_raw;

  initial begin
    vec_w_min_chk: assert (VEC_W >= MIN_VEC_W);
  end

  hs_irq_cand #(.VEC_W(VEC_W)) u_cand (
    .pend_i(pend_i), .en_i(en_i), .cand_o(cand)
  );

  hs_irq_pick #(.CAUSE_W(CAUSE_W)) u_pick (
    .cand_i(cand), .found_o(found), .cause_o(cause_raw)
  );

  hs_irq_out #(.CAUSE_W(CAUSE_W), .OUT_REG(OUT_REG)) u_out (
    .clk(clk), .rst_n(rst_n), .found_i(found), .cause_i(cause_raw),
    .take_o(take_o), .cause_o(cause_o)
  );

  // Checking view of pend & en, aligned with the outputs.
  logic [VEC_W-1:0] hit, ref_hit;
  assign hit = pend_i & en_i;
  if (OUT_REG) begin : g_ref_reg
    always_ff @(posedge clk) begin
      if (!rst_n) ref_hit <= '0;
      else        ref_hit <= hit;
    end
  end else begin : g_ref_comb
    assign ref_hit = hit;
  end

  // R9
  idle_cause_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> cause_o == '0);
  // R1
  take_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ref_hit[cause_o]);
  // R2
  s_ext_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_hit[9] |-> take_o && cause_o == CAUSE_W'(9));
  // R5
  guest_over_vs_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hit[12] && ref_hit[10]) |-> cause_o != CAUSE_W'(10));
  // R7
  vs_soft_over_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hit[2] && ref_hit[6]) |-> cause_o != CAUSE_W'(6));
endmodule

// File: tb/hs_irq_select_bench.sv
`timescale 1ns/1ps
module hs_irq_select_bench;
  localparam int VEC_W = 13;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [VEC_W-1:0] pend = '0, en = '0;
  logic take;
  logic [CW-1:0] cause;

  always #2.5 clk = ~clk;

  hs_irq_select u_hs_irq_select (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en),
    .take_o(take), .cause_o(cause)
  );

  typedef struct {
    logic          take;
    logic [CW-1:0] cause;
    string         tag;
  } exp_t;

  exp_t sbq[$];
  int n_run = 0, n_fail = 0;
  bit drv_done = 1'b0;

  // Ranking from the requirements: 9,1,5,12,10,2,6.
  function automatic exp_t model(input logic [VEC_W-1:0] p, input logic [VEC_W-1:0] e, input string tag);
    int order [7] = '{9, 1, 5, 12, 10, 2, 6};
    exp_t x;
    x.take = 1'b0; x.cause = '0; x.tag = tag;
    for (int i = 0; i < 7; i++) begin
      if (!x.take && p[order[i]] && e[order[i]]) begin
        x.take = 1'b1; x.cause = CW'(order[i]);
      end
    end
    return x;
  endfunction

  task automatic drive(input logic [VEC_W-1:0] p, input logic [VEC_W-1:0] e, input string tag);
    @(negedge clk);
    pend = p; en = e;
    sbq.push_back(model(p, e, tag));
  endtask

  task automatic both(input logic [VEC_W-1:0] v, input string tag);
    drive(v, v, tag);
  endtask

  // Monitor: registered output reflects inputs from the previous negedge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && sbq.size() > 0) begin
        exp_t x;
        x = sbq.pop_front();
        n_run++;
        if (take !== x.take || cause !== x.cause) begin
          n_fail++;
          $display("FAIL %s: take=%0b cause=%0d expected take=%0b cause=%0d",
                   x.tag, take, cause, x.take, x.cause);
        end
      end
    end
  end

  initial begin
    // R11: reset state
    pend = '1; en = '1;
    repeat (3) @(negedge clk);
    n_run++;
    if (take !== 1'b0 || cause !== '0) begin
      n_fail++;
      $display("FAIL R11: take=%0b cause=%0d expected take=0 cause=0", take, cause);
    end
    @(negedge clk);
    rst_n = 1'b1;
    pend = '0; en = '0;

    both('0, "R9");
    drive(13'h1fff, 13'h0, "R1");
    drive(13'h0, 13'h1fff, "R1");
    drive(13'h1666, 13'h0999, "R1");
    for (int b = 0; b < VEC_W; b++) both(VEC_W'(1) << b, "R8");
    both(13'b0_1001_1001_1001, "R10");
    both(13'h1fff, "R2");
    both(13'h1fff & ~13'h0200, "R3");
    both((1 << 5) | (1 << 12) | (1 << 10) | (1 << 2) | (1 << 6), "R4");
    both((1 << 12) | (1 << 10), "R5");
    both((1 << 12) | (1 << 10) | (1 << 2) | (1 << 6), "R5");
    both((1 << 10) | (1 << 2) | (1 << 6), "R6");
    both((1 << 2) | (1 << 6), "R7");
    drive((1 << 2) | (1 << 6), (1 << 6), "R7");
    both('0, "R9");
    for (int i = 0; i < 300; i++)
      drive(VEC_W'($urandom), VEC_W'($urandom), "R8");
    both('0, "R9");
    repeat (3) @(negedge clk);
    drv_done = 1'b1;
  end

  initial begin
    fork
      wait (drv_done && sbq.size() == 0);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule